// File: doc/BRIEF.md
# Ring and Line-Reversal Event Detector

This block is the digital form of a call-arrival detector. Its input is one line-event signal that has already been thresholded: it is active while a line polarity reversal, a single ring burst or a normal ringing cycle is present at the line interface. The block first synchronizes that signal to the local clock. It then drives an active-low event output, which goes low as soon as the event is seen. After the input goes inactive, the output stays low for a programmable hold interval.

Each new input pulse restarts the hold timer. Because of this, a ring waveform of about 25 Hz becomes one continuous low envelope instead of one pulse per ring cycle. Set the hold value to zero when the output should follow the synchronized input exactly. Software can then time the ring duration itself.

The hold value counts ticks of roughly 1 ms. A prescaler derives each tick from the clock. The output also comes with a one-cycle wake strobe, which a sleeping controller can use to resume work. The detector has no power-down gating, so it keeps running while the rest of the device sleeps. The block has no streaming data path: every pin is a plain level or strobe, and there is no back-pressure.

Top module: `line_event_detect`

## Requirements
- R1: During reset and after it, until an event is seen, `event_n_o` is 1 and `wake_o` is 0.
- R2: A rising edge on `line_evt_i` pulls `event_n_o` low exactly 3 clock cycles later. The 3 cycles are two synchronizer stages plus the output register.
- R3: When `hold_ms_i` is 0 (follow mode), `event_n_o` is low for exactly as many cycles as `line_evt_i` was high. A train of separated pulses gives one separate low interval per pulse.
- R4: When `hold_ms_i` = H > 0, a single input pulse of W cycles produces one low interval of W + H*T cycles. T is the parameter `TICK_CYCLES`, the number of clocks in one tick. The tick prescaler restarts whenever the synchronized input is active.
- R5: In hold mode, an input pulse that arrives while the output is still low restarts the hold count. A pulse train whose gaps are shorter than H*T cycles therefore yields one envelope. The envelope runs from 3 cycles after the first rising edge until H*T cycles after the last pulse would have ended in follow mode.
- R6: `wake_o` is high for exactly one cycle, namely the first cycle in which `event_n_o` is low. It pulses once per low interval, and once for a whole retriggered envelope.
- R7: `hold_ms_i` is read live. If it is lowered during a hold to a value at or below the ticks already elapsed, the output returns high on the next tick. The count does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_evt_i | input | 1 | Thresholded line-event level, active high, asynchronous to `clk` |
| hold_ms_i | input | HOLD_W (16) | Hold interval in ticks; 0 selects follow mode |
| event_n_o | output | 1 | Event envelope, active low |
| wake_o | output | 1 | One-cycle strobe on the high-to-low transition of `event_n_o` |

## Verification
The bench drives the block with single pulses in follow mode, both one cycle and several cycles wide. It also drives a single pulse with a nonzero hold, which shows whether the hold length is added exactly once, with the prescaler restarted at release. A simulated ring train is applied with a hold longer than its gaps, and the same kind of train is applied with the hold at zero. The pair separates envelope merging from pass-through, and it checks that only one wake strobe appears per envelope. A final case lowers the hold value in the middle of a hold and measures when the output releases, which exposes any wrap or stale compare.

// File: rtl/rle_pkg.sv
package rle_pkg;
  typedef enum logic {
    MODE_FOLLOW = 1'b0,
    MODE_HOLD   = 1'b1
  } hold_mode_e;

  localparam int unsigned DEF_HOLD_W = 16;
endpackage

// File: rtl/rle_sync.sv
module rle_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rle_tick.sv
module rle_tick #(
  parameter int unsigned DIV = 100_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] pc_q;
  logic          tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      tick_q <= 1'b0;
    end else if (clr_i) begin
      pc_q   <= '0;
      tick_q <= 1'b0;
    end else if (pc_q == LAST) begin
      pc_q   <= '0;
      tick_q <= 1'b1;
    end else begin
      pc_q   <= pc_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  // R4: an active input holds the prescaler idle
  a_r4_clr_kills_tick: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !tick_o);

  generate
    if (DIV > 1) begin : g_sparse
      // R4: ticks are isolated when the divider exceeds one
      a_r4_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/rle_hold.sv
module rle_hold
  import rle_pkg::*;
#(
  parameter int unsigned HOLD_W = DEF_HOLD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_i,
  input  logic              tick_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              held_o,
  output logic              wake_o
);
  hold_mode_e        mode;
  logic [HOLD_W-1:0] cnt_q;
  logic [HOLD_W:0]   cnt_inc;
  logic              held_q;
  logic              wake_q;

  assign mode    = (hold_i == '0) ? MODE_FOLLOW : MODE_HOLD;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      cnt_q  <= '0;
      wake_q <= 1'b0;
    end else begin
      wake_q <= evt_i && !held_q;
      if (evt_i) begin
        held_q <= 1'b1;
        cnt_q  <= '0;
      end else if (held_q) begin
        if (mode == MODE_FOLLOW) begin
          held_q <= 1'b0;
          cnt_q  <= '0;
        end else if (tick_i) begin
          if (cnt_inc >= {1'b0, hold_i}) begin
            held_q <= 1'b0;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_inc[HOLD_W-1:0];
          end
        end
      end
    end
  end

  assign held_o = held_q;
  assign wake_o = wake_q;

  // R2: a synchronized event always leaves the envelope active
  a_r2_evt_sets_held: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> held_o);

  // R3: follow mode releases one cycle after the input drops
  a_r3_follow_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_i && hold_i == '0) |=> !held_o);

  // R6: wake accompanies the start of every envelope
  a_r6_wake_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_o) |-> wake_o);

  // R6: wake only while envelope active
  a_r6_wake_in_env: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> held_o);

  // R4: without input and without a tick the envelope cannot end in hold mode
  a_r4_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
    (held_o && !evt_i && !tick_i && hold_i != '0) |=> held_o);
endmodule

// File: rtl/line_event_detect.sv
module line_event_detect
  import rle_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 100_000,
  parameter int unsigned HOLD_W      = DEF_HOLD_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_evt_i,
  input  logic [HOLD_W-1:0] hold_ms_i,
  output logic              event_n_o,
  output logic              wake_o
);
  logic evt_s;
  logic tick;
  logic held;
  logic wake;

  rle_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (line_evt_i),
    .q_o   (evt_s)
  );

  rle_tick #(.DIV(TICK_CYCLES)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (evt_s),
    .tick_o (tick)
  );

  rle_hold #(.HOLD_W(HOLD_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_s),
    .tick_i (tick),
    .hold_i (hold_ms_i),
    .held_o (held),
    .wake_o (wake)
  );

  assign event_n_o = !held;
  assign wake_o    = wake;

  // R6: the strobe lasts one cycle
  a_r6_wake_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  // R6: a falling output always carries the strobe
  a_r6_fall_has_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(event_n_o) |-> wake_o);

  // R1: strobe never while output idle high
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    event_n_o |-> !wake_o);
endmodule

// File: tb/line_event_detect_bench.sv
module line_event_detect_bench;
  localparam int unsigned D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_evt = 1'b0;
  logic [15:0] hold = '0;
  logic        event_n;
  logic        wake;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    start;
    int    width;
    string tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  line_event_detect #(.TICK_CYCLES(D)) u_line_event_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_evt_i (line_evt),
    .hold_ms_i  (hold),
    .event_n_o  (event_n),
    .wake_o     (wake)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // drives a train of n pulses, each w cycles wide, repeating every p cycles
  task automatic train(input int n, input int w, input int p, input int h, input string tag);
    int t0;
    @(posedge clk); #1;
    t0 = cyc;
    if (h == 0) begin
      for (int k = 0; k < n; k++) q.push_back('{t0 + k*p + 3, w, tag});
    end else begin
      q.push_back('{t0 + 3, (n-1)*p + w + h*D, tag});
    end
    for (int k = 0; k < n; k++) begin
      line_evt = 1'b1;
      idle(w);
      line_evt = 1'b0;
      if (k != n-1) idle(p - w);
    end
  endtask

  // monitor: measure each low interval at negedge and compare with queue
  int lo_start, lo_len, wake_cnt, wake_first;
  bit in_low = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!event_n) begin
        if (!in_low) begin
          in_low = 1'b1; lo_start = cyc; lo_len = 0; wake_cnt = 0; wake_first = wake;
        end
        lo_len++;
        if (wake) wake_cnt++;
      end else begin
        if (wake) check(1'b0, "R6 wake while idle", 1, 0);
        if (in_low) begin
          exp_t e;
          in_low = 1'b0;
          if (q.size() == 0) begin
            check(1'b0, "R3 unexpected low interval", lo_start, -1);
          end else begin
            e = q.pop_front();
            check(lo_start == e.start, {e.tag, " R2 start"}, lo_start, e.start);
            check(lo_len == e.width, {e.tag, " width"}, lo_len, e.width);
            check(wake_cnt == 1 && wake_first == 1, {e.tag, " R6 wake count"}, wake_cnt, 1);
          end
        end
      end
    end
  end

  initial begin
    int t0;
    #2;
    check(event_n == 1'b1, "R1 event_n in reset", event_n, 1);
    check(wake == 1'b0, "R1 wake in reset", wake, 0);
    idle(3);
    rst_n = 1'b1;
    idle(4);
    check(event_n == 1'b1, "R1 event_n after reset", event_n, 1);
    check(wake == 1'b0, "R1 wake after reset", wake, 0);

    hold = 16'd0;
    train(1, 5, 10, 0, "R3 follow w5");
    idle(10);
    train(1, 1, 10, 0, "R3 follow w1");
    idle(10);
    hold = 16'd3;
    train(1, 6, 10, 3, "R4 hold3 w6");
    idle(30);
    hold = 16'd5;
    train(4, 3, 8, 5, "R5 ring envelope");
    idle(40);
    hold = 16'd0;
    train(3, 3, 8, 0, "R3 ring follow");
    idle(10);

    // R7: hold lowered mid-interval
    hold = 16'd10;
    @(posedge clk); #1;
    t0 = cyc;
    q.push_back('{t0 + 3, 4 + 3*D, "R7 live hold change"});
    line_evt = 1'b1;
    idle(4);
    line_evt = 1'b0;
    idle(13);
    hold = 16'd1;
    idle(30);
    hold = 16'd0;

    idle(10);
    check(q.size() == 0, "R5 leftover expected items", q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule